// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two packed single-precision binary floating-point values. Each value has a sign bit, an 8-bit biased exponent with a bias of 127, and a 23-bit fraction. A normal value carries an implicit leading one that is not stored. The block restores the hidden bits and forms the full 48-bit significand product. It builds the result exponent from the sum of the biased exponents less one bias. It then normalizes, rounds to nearest-even with guard, round and sticky bits, and renormalizes if rounding carries out. The result sign is the XOR of the operand signs. Reserved exponent codes are decoded before any arithmetic:

- An exponent of all ones marks infinity or NaN.
- An exponent of all zeros marks zero. Denormal operands are flushed and treated as zero.

Operands enter on a valid/ready stream, and the packed product leaves on another with three flags: invalid, overflow and underflow. The pipeline has three register stages. A beat presented in cycle c appears on the output in cycle c+3 when the output is not stalled. Back-pressure rules:

- While `out_valid` is high and `out_ready` is low, the whole pipeline freezes.
- During that freeze the output beat is held unchanged and `in_ready` is low, so no beat is taken or lost.
- When `out_ready` is high, one beat per cycle flows through.

The exponent and fraction widths are parameters. With the defaults the block has the single-precision layout.

Top module: `fpmul_sp`

## Requirements
- R1: For two normal operands, the result has sign = XOR of the signs (bit 31), exponent field (bits 30:23) = ea + eb − 127 plus the normalization shift, and fraction (bits 22:0) = the normalized product of 1.fa × 1.fb. No flag is set when the rounded exponent lies in 1..254.
- R2: The product is rounded to nearest using the guard bit, the round bit and the sticky OR of the remaining bits. An exact half-way case rounds to the even kept fraction.
- R3: When rounding carries the significand up to 2.0, the significand is shifted right once more and the exponent is incremented.
- R4: If the exponent after rounding exceeds 254, the result is infinity with the product's sign and `out_ovf` is 1.
- R5: If the exponent after rounding is below 1, the result is zero with the product's sign and `out_unf` is 1. The test uses the exponent after rounding, so a carry that lifts it to 1 gives a normal result.
- R6: A NaN operand (exponent 255, fraction ≠ 0), or infinity times zero, gives the quiet NaN 0x7FC00000 and sets `out_inv` to 1.
- R7: Infinity times a nonzero finite value gives infinity with the product's sign. Zero times a finite value gives zero with the product's sign. Neither case sets a flag.
- R8: An operand with exponent field 0 and a nonzero fraction is treated exactly as a zero of its sign. It never raises underflow, and times infinity it gives R6's NaN.
- R9: With `out_ready` held high, a beat accepted in cycle c is presented with `out_valid` high in cycle c+3 and not before. One beat per cycle is sustained.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output beat and flags stay unchanged and `in_ready` is 0. Every accepted beat is delivered once, in order.
- R11: At most one of `out_inv`, `out_ovf` and `out_unf` is 1 on any output beat.
- R12: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block takes the operand pair this cycle |
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| out_valid | output | 1 | Product beat is present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_result | output | 32 | Packed product |
| out_ovf | output | 1 | Result overflowed to infinity |
| out_unf | output | 1 | Result underflowed to zero |
| out_inv | output | 1 | Invalid operation, result is quiet NaN |

## Verification
Rounding and the range check can act on the same product. A rounding carry may push an exponent of 254 to 255, which must give overflow. It may also lift an exponent of 0 to 1, which must give a normal value and no underflow. The bench provokes both with an exhaustive sweep of every operand pair on a reduced 4-bit-exponent, 3-bit-fraction instance. Irregular back-pressure runs during the sweep. Each result is judged against a reference that multiplies the integer significands exactly, divides and takes the remainder, then applies the range limits to the rounded exponent.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

  // Operand class after decoding the reserved exponent codes.
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;

  typedef struct packed {
    logic inv;
    logic ovf;
    logic unf;
  } fp_flags_t;

endpackage

// File: rtl/fpmul_unpack.sv
module fpmul_unpack
  import fpmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp,
  output logic [FRAC_W:0]       mant,
  output fp_cls_e               cls
);
  logic [FRAC_W-1:0] frac;

  assign sign = op[EXP_W+FRAC_W];
  assign exp  = op[EXP_W+FRAC_W-1:FRAC_W];
  assign frac = op[FRAC_W-1:0];
  assign mant = {1'b1, frac};

  // Zero exponent means no hidden bit; denormals are flushed to zero here.
  always_comb begin
    if (exp == '0)
      cls = CLS_ZERO;
    else if (exp == '1)
      cls = (frac == '0) ? CLS_INF : CLS_NAN;
    else
      cls = CLS_NORM;
  end
endmodule

// File: rtl/fpmul_round.sv
module fpmul_round #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 1,
  localparam int PROD_W = 2 * MANT_W,
  localparam int ESW    = EXP_W + 2,
  localparam int EMAX   = (1 << EXP_W) - 1
) (
  input  logic [PROD_W-1:0]     prod,
  input  logic signed [ESW-1:0] exp_in,
  input  logic                  sign,
  output logic [W-1:0]          result,
  output logic                  ovf,
  output logic                  unf
);
  logic [PROD_W-1:0]     norm;
  logic [MANT_W-1:0]     kept;
  logic                  g_bit, r_bit, s_bit, rnd_up;
  logic [MANT_W:0]       rsum;
  logic                  carry;
  logic signed [ESW-1:0] e_fin;

  // Product of two 1.x significands lies in [1,4): at most one left shift.
  assign norm  = prod[PROD_W-1] ? prod : (prod << 1);
  assign kept  = norm[PROD_W-1 -: MANT_W];
  assign g_bit = norm[MANT_W-1];
  assign r_bit = norm[MANT_W-2];
  assign s_bit = |norm[MANT_W-3:0];

  // Nearest-even: round up above half, or at exactly half when kept is odd.
  assign rnd_up = g_bit & (r_bit | s_bit | kept[0]);
  assign rsum   = {1'b0, kept} + {{MANT_W{1'b0}}, rnd_up};
  assign carry  = rsum[MANT_W];

  // On carry rsum is 10..0, so its low fraction bits already read as the
  // significand 1.0 after the extra right shift; only the exponent moves.
  assign e_fin = exp_in
               + $signed({{(ESW-1){1'b0}}, prod[PROD_W-1]})
               + $signed({{(ESW-1){1'b0}}, carry});

  always_comb begin
    ovf    = 1'b0;
    unf    = 1'b0;
    result = {sign, e_fin[EXP_W-1:0], rsum[FRAC_W-1:0]};
    if (e_fin > ESW'(EMAX - 1)) begin
      ovf    = 1'b1;
      result = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (e_fin < ESW'(1)) begin
      unf    = 1'b1;
      result = {sign, {(W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/fpmul_sp.sv
module fpmul_sp
  import fpmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W,
  localparam int MANT_W = FRAC_W + 1,
  localparam int PROD_W = 2 * MANT_W,
  localparam int ESW    = EXP_W + 2,
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_ovf,
  output logic         out_unf,
  output logic         out_inv
);
  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // ---------------- operand decode ----------------
  logic [W-1:0]       opnd   [2];
  logic               u_sign [2];
  logic [EXP_W-1:0]   u_exp  [2];
  logic [MANT_W-1:0]  u_mant [2];
  fp_cls_e            u_cls  [2];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_unp
    fpmul_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
      .op   (opnd[g]),
      .sign (u_sign[g]),
      .exp  (u_exp[g]),
      .mant (u_mant[g]),
      .cls  (u_cls[g])
    );
  end

  // Whole pipe advances together; the last stage is the only one that can block.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // ---------------- stage 1: specials and exponent sum ----------------
  logic                  p_sign, p_special, nan_any, inf_zero, inf_any, zero_any;
  logic [W-1:0]          p_spec_res;
  fp_flags_t             p_spec_flg;
  logic signed [ESW-1:0] p_exp;

  assign p_sign   = u_sign[0] ^ u_sign[1];
  assign nan_any  = (u_cls[0] == CLS_NAN) || (u_cls[1] == CLS_NAN);
  assign inf_any  = (u_cls[0] == CLS_INF) || (u_cls[1] == CLS_INF);
  assign zero_any = (u_cls[0] == CLS_ZERO) || (u_cls[1] == CLS_ZERO);
  assign inf_zero = inf_any && zero_any;
  assign p_exp    = $signed({2'b00, u_exp[0]}) + $signed({2'b00, u_exp[1]})
                  - ESW'(BIAS);

  always_comb begin
    p_special  = 1'b1;
    p_spec_flg = '0;
    p_spec_res = {p_sign, {(W-1){1'b0}}};
    if (nan_any || inf_zero) begin
      p_spec_res     = QNAN;
      p_spec_flg.inv = 1'b1;
    end else if (inf_any) begin
      p_spec_res = {p_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (!zero_any) begin
      p_special = 1'b0;
    end
  end

  logic                  s1_valid, s1_sign, s1_special;
  logic [W-1:0]          s1_spec_res;
  fp_flags_t             s1_spec_flg;
  logic signed [ESW-1:0] s1_exp;
  logic [MANT_W-1:0]     s1_ma, s1_mb;

  // ---------------- stage 2: significand product ----------------
  logic                  s2_valid, s2_sign, s2_special;
  logic [W-1:0]          s2_spec_res;
  fp_flags_t             s2_spec_flg;
  logic signed [ESW-1:0] s2_exp;
  logic [PROD_W-1:0]     s2_prod;

  // ---------------- stage 3: normalize, round, pack ----------------
  logic [W-1:0] r_res;
  logic         r_ovf, r_unf;

  fpmul_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
    .prod   (s2_prod),
    .exp_in (s2_exp),
    .sign   (s2_sign),
    .result (r_res),
    .ovf    (r_ovf),
    .unf    (r_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s2_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_valid  <= in_valid;
      s2_valid  <= s1_valid;
      out_valid <= s2_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_sign     <= p_sign;
      s1_special  <= p_special;
      s1_spec_res <= p_spec_res;
      s1_spec_flg <= p_spec_flg;
      s1_exp      <= p_exp;
      s1_ma       <= u_mant[0];
      s1_mb       <= u_mant[1];

      s2_sign     <= s1_sign;
      s2_special  <= s1_special;
      s2_spec_res <= s1_spec_res;
      s2_spec_flg <= s1_spec_flg;
      s2_exp      <= s1_exp;
      s2_prod     <= PROD_W'(s1_ma) * PROD_W'(s1_mb);

      if (s2_special) begin
        out_result <= s2_spec_res;
        out_inv    <= s2_spec_flg.inv;
        out_ovf    <= s2_spec_flg.ovf;
        out_unf    <= s2_spec_flg.unf;
      end else begin
        out_result <= r_res;
        out_inv    <= 1'b0;
        out_ovf    <= r_ovf;
        out_unf    <= r_unf;
      end
    end
  end
endmodule

// File: rtl/fpmul_sp_chk.sv
module fpmul_sp_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = 1 + EXP_W + FRAC_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_ovf,
  input logic         out_unf,
  input logic         out_inv
);
  localparam logic [W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // Cycles since reset, saturating, so the latency check never reaches back
  // into reset.
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable({out_inv, out_ovf, out_unf}));

  a_r10_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_inv, out_ovf, out_unf}));

  a_r6_inv_gives_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inv |-> out_result == QNAN);

  a_r4_ovf_gives_inf: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

  a_r5_unf_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |-> out_result[W-2:0] == '0);

  a_r9_three_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && out_ready && $past(out_ready) && $past(out_ready, 2)
      && $past(in_valid && in_ready, 3) |-> out_valid);
endmodule

bind fpmul_sp fpmul_sp_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_ovf    (out_ovf),
  .out_unf    (out_unf),
  .out_inv    (out_inv)
);

// File: tb/fpmul_sp_tb.sv
module fpmul_sp_tb;
  // ---------------- clock, counters ----------------
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      errors++;
      $display("FAIL R9 watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
    end
  end

  // ---------------- reduced instance: 4-bit exponent, 3-bit fraction ----------------
  logic       v8 = 1'b0, rdy8 = 1'b1;
  logic [7:0] a8 = '0, b8 = '0;
  logic       in_rdy8, ov8, o_ovf8, o_unf8, o_inv8;
  logic [7:0] res8;

  fpmul_sp #(.EXP_W(4), .FRAC_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_ready(in_rdy8),
    .in_a(a8), .in_b(b8), .out_valid(ov8), .out_ready(rdy8),
    .out_result(res8), .out_ovf(o_ovf8), .out_unf(o_unf8), .out_inv(o_inv8));

  // ---------------- full-width instance ----------------
  logic        v32 = 1'b0;
  logic        rdy32 = 1'b1;
  logic [31:0] a32 = '0, b32 = '0;
  logic        in_rdy32, ov32, o_ovf32, o_unf32, o_inv32;
  logic [31:0] res32;

  fpmul_sp u_dut32 (
    .clk(clk), .rst_n(rst_n), .in_valid(v32), .in_ready(in_rdy32),
    .in_a(a32), .in_b(b32), .out_valid(ov32), .out_ready(rdy32),
    .out_result(res32), .out_ovf(o_ovf32), .out_unf(o_unf32), .out_inv(o_inv32));

  // Reference for the reduced format (bias 7, exponent 15 reserved).
  // Returns {tag[3:0], inv, ovf, unf, result[7:0]}.
  function automatic logic [14:0] ref8(input logic [7:0] a, input logic [7:0] b);
    int ea, eb, fa, fb, p, e, dv, q, rm, half, tag;
    bit s, za, zb, ia, ib, na, nb, dn;
    s  = a[7] ^ b[7];
    ea = int'(a[6:3]); eb = int'(b[6:3]);
    fa = int'(a[2:0]); fb = int'(b[2:0]);
    za = (ea == 0); zb = (eb == 0);
    ia = (ea == 15) && (fa == 0); ib = (eb == 15) && (fb == 0);
    na = (ea == 15) && (fa != 0); nb = (eb == 15) && (fb != 0);
    dn = (za && fa != 0) || (zb && fb != 0);
    if (na || nb || (ia && zb) || (za && ib))
      return {4'd6, 3'b100, 8'h7C};
    if (ia || ib)
      return {4'd7, 3'b000, s, 7'b1111000};
    if (za || zb)
      return {(dn ? 4'd8 : 4'd7), 3'b000, s, 7'b0};
    p  = (8 + fa) * (8 + fb);
    e  = ea + eb - 7;
    dv = (p >= 128) ? 16 : 8;
    if (p >= 128) e++;
    q    = p / dv;
    rm   = p % dv;
    half = dv / 2;
    tag  = (rm != 0) ? 2 : 1;
    if (rm > half || (rm == half && (q % 2) == 1)) q++;
    if (q == 16) begin q = 8; e++; tag = 3; end
    if (e >= 15) return {4'd4, 3'b010, s, 7'b1111000};
    if (e < 1)   return {4'd5, 3'b001, s, 7'b0};
    return {4'(tag), 3'b000, s, 4'(e), 3'(q - 8)};
  endfunction

  function automatic string tname(input int t);
    case (t)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 6: return "R6"; 7: return "R7"; default: return "R8";
    endcase
  endfunction

  // One isolated beat on the full-width instance, with exact latency check.
  task automatic run32(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] er, input logic [2:0] ef, input string tag);
    @(negedge clk);
    a32 = a; b32 = b; v32 = 1'b1;
    @(negedge clk);
    v32 = 1'b0;
    @(negedge clk);
    #1 chk(!ov32, "R9 early", {63'd0, ov32}, 64'd0);
    @(negedge clk);
    #1 chk(ov32, "R9 on time", {63'd0, ov32}, 64'd1);
    chk({o_inv32, o_ovf32, o_unf32, res32} == {ef, er}, tag,
        {29'd0, o_inv32, o_ovf32, o_unf32, res32}, {29'd0, ef, er});
  endtask

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(!ov8 && !ov32, "R12 valid in reset", {62'd0, ov8, ov32}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(!ov8 && in_rdy8 && in_rdy32, "R12 after reset",
           {61'd0, ov8, in_rdy8, in_rdy32}, 64'd3);

    // Full-width directed cases: {inv,ovf,unf}
    run32(32'h3FC00000, 32'h40000000, 32'h40400000, 3'b000, "R1 1.5*2");
    run32(32'hBF400000, 32'h40000000, 32'hBFC00000, 3'b000, "R1 -0.75*2");
    run32(32'h3F000000, 32'hBEE00000, 32'hBE600000, 3'b000, "R1 0.5*-0.4375");
    run32(32'h3F800800, 32'h3F800800, 32'h3F801000, 3'b000, "R2 tie to even");
    run32(32'h7F000000, 32'h40000000, 32'h7F800000, 3'b010, "R4 overflow");
    run32(32'h00800000, 32'h3F000000, 32'h00000000, 3'b001, "R5 underflow");
    run32(32'h7F800000, 32'h00000000, 32'h7FC00000, 3'b100, "R6 inf*0");
    run32(32'h7F800001, 32'h3F800000, 32'h7FC00000, 3'b100, "R6 nan operand");
    run32(32'hFF800000, 32'h40000000, 32'hFF800000, 3'b000, "R7 -inf*2");
    run32(32'h80000000, 32'h40400000, 32'h80000000, 3'b000, "R7 -0*3");
    run32(32'h00000001, 32'h7F800000, 32'h7FC00000, 3'b100, "R8 denormal*inf");
    run32(32'h00000005, 32'h3F800000, 32'h00000000, 3'b000, "R8 denormal*1");

    // Exhaustive sweep on the reduced instance under irregular back-pressure.
    begin
      int sent = 0;
      int got = 0;
      int k = 0;
      bit held_v = 1'b0;
      logic [10:0] held = '0;
      while (got < 65536) begin
        @(negedge clk);
        k++;
        rdy8 = !((k % 7) == 3 || (k % 11) == 5);
        v8 = (sent < 65536);
        a8 = 8'(sent >> 8);
        b8 = 8'(sent);
        #1;
        if (held_v)
          chk(ov8 && {o_inv8, o_ovf8, o_unf8, res8} == held, "R10 hold",
              {52'd0, ov8, o_inv8, o_ovf8, o_unf8, res8}, {52'd0, 1'b1, held});
        held_v = 1'b0;
        if (ov8 && !rdy8) begin
          chk(!in_rdy8, "R10 no take", {63'd0, in_rdy8}, 64'd0);
          held_v = 1'b1;
          held = {o_inv8, o_ovf8, o_unf8, res8};
        end
        if (ov8 && rdy8) begin
          logic [14:0] r;
          r = ref8(8'(got >> 8), 8'(got));
          chk({o_inv8, o_ovf8, o_unf8, res8} == r[10:0], tname(int'(r[14:11])),
              {53'd0, o_inv8, o_ovf8, o_unf8, res8}, {53'd0, r[10:0]});
          got++;
        end
        if (v8 && in_rdy8) sent++;
      end
      v8 = 1'b0;
      rdy8 = 1'b1;
      repeat (6) @(negedge clk);
      #1 chk(!ov8, "R10 no extra beat", {63'd0, ov8}, 64'd0);
    end
    finish_run();
  end
endmodule